// File: doc/BRIEF.md
# Balanced Parallel Link Codec

This block carries a 192-bit word across one parallel die-to-die link of seven single-ended NRZ lanes. On the transmit side, one word is accepted through a valid/ready handshake. It is then sent over 32 consecutive beats. Each beat carries six payload bits, one bit from each of six 32-bit groups of the word, mapped to a seven-bit codeword. Every codeword has three or four lanes high. The number of high and low lanes in a single beat is therefore always nearly equal, which keeps the switching current across the link balanced from beat to beat.

On the receive side, each incoming beat is mapped back to its six payload bits. Values outside the codebook are flagged, and their payload is forced to zero. After the 32nd beat, the block presents the reassembled 192-bit word for one cycle, together with a flag that shows whether any of its beats was illegal. In normal use, the lane outputs of one end are wired to the lane inputs of the other end.

Top module: `bpl_codec`

## Requirements
- R1: Payload value v (0..63) is sent as the v-th entry, counted from zero, of the 7-bit values with exactly three or four ones, listed in ascending numeric order. For example, 0 maps to 7'h07, 1 to 7'h0B, 4 to 7'h0F and 63 to 7'h6A.
- R2: Every beat with `lanesOutValid` high has three or four lanes at one.
- R3: Beat k of a word (k = 0..31) carries payload bit j = word bit 32*j+k, and the beats go out in ascending k on consecutive cycles. `lanesOutValid` first rises two clock edges after the edge that accepts an idle word.
- R4: `txReady` is high when the transmitter is idle and during the last beat of a word, and low during the other beats. A word accepted during a last beat follows that beat with no gap.
- R5: The receiver maps every codeword of R1 back to its payload value.
- R6: A received value that is not one of the 64 codewords is illegal. This includes weights other than 3 or 4, and the six unused balanced values 7'h6C, 7'h70, 7'h71, 7'h72, 7'h74 and 7'h78. For an illegal value, `rxBeatErr` is high in the cycle after the beat and the payload taken for that beat is zero. For a legal value, `rxBeatErr` is low in that cycle.
- R7: `rxWordValid` is a one-cycle pulse in the cycle after the 32nd received beat, with `rxWord` assembled by the bit map of R3.
- R8: `rxWordErr`, valid with `rxWordValid`, is high if and only if at least one beat of that word was illegal. It does not carry over into the next word.
- R9: After reset, `txReady` is 1, `lanesOut` is 0, and `lanesOutValid`, `rxWordValid`, `rxBeatErr` and `rxWordErr` are 0.
- R10: While `lanesOutValid` is low, `lanesOut` keeps the value of the last beat sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txWord | input | 192 | Word to transmit |
| txValid | input | 1 | Word offered |
| txReady | output | 1 | Word can be accepted this cycle |
| lanesOut | output | 7 | Lane levels of the current beat |
| lanesOutValid | output | 1 | `lanesOut` carries a beat |
| lanesIn | input | 7 | Received lane levels |
| lanesInValid | input | 1 | `lanesIn` carries a beat |
| rxWord | output | 192 | Reassembled word |
| rxWordValid | output | 1 | `rxWord` is complete (one-cycle pulse) |
| rxWordErr | output | 1 | At least one beat of this word was illegal |
| rxBeatErr | output | 1 | The previous received beat was illegal |

## Verification
Word acceptance, beat emission and beat decoding each fall on a fixed cycle. The first beat of a word accepted while idle appears two edges after acceptance. A per-beat error flag appears one edge after that beat, and the word pulse appears one edge after the 32nd beat. The bench samples at falling edges. A scoreboard pops one expected codeword for every cycle in which `lanesOutValid` is high, and one expected word with its error flag for every `rxWordValid` pulse, so order and count are both checked. The exact first-beat latency and the per-beat error timing are checked on the named cycles.

// File: rtl/bpl_pkg.sv
package bpl_pkg;

  parameter int PAY_W  = 6;
  parameter int LANE_W = 7;
  parameter int BEATS  = 32;

  localparam int WORD_W     = PAY_W * BEATS;
  localparam int BEAT_W     = $clog2(BEATS);
  localparam int CODE_SPACE = 1 << LANE_W;
  localparam int NUM_CODES  = 1 << PAY_W;
  localparam int WEIGHT_LO  = LANE_W / 2;
  localparam int WEIGHT_HI  = LANE_W - WEIGHT_LO;

  // Strobes from control to datapath
  typedef struct packed {
    logic              loadWord;
    logic              emitBeat;
    logic [BEAT_W-1:0] txIdx;
    logic              takeBeat;
    logic              firstBeat;
    logic              lastBeat;
  } bpl_strb_t;

  typedef struct packed {
    logic             bad;
    logic [PAY_W-1:0] pay;
  } bpl_dec_t;

  function automatic int lane_weight(input logic [LANE_W-1:0] v);
    int n = 0;
    for (int i = 0; i < LANE_W; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic logic is_balanced(input logic [LANE_W-1:0] v);
    int w;
    w = lane_weight(v);
    return (w == WEIGHT_LO) || (w == WEIGHT_HI);
  endfunction

  // Payload value p -> p-th balanced value in ascending order
  function automatic logic [LANE_W-1:0] code_of(input logic [PAY_W-1:0] p);
    int rank = 0;
    logic [LANE_W-1:0] cw;
    logic [LANE_W-1:0] res = '0;
    for (int c = 0; c < CODE_SPACE; c++) begin
      cw = c[LANE_W-1:0];
      if (is_balanced(cw)) begin
        if (rank == int'(p)) res = cw;
        rank++;
      end
    end
    return res;
  endfunction

  // Inverse map; anything outside the first NUM_CODES balanced values is bad
  function automatic bpl_dec_t decode_of(input logic [LANE_W-1:0] v);
    int rank = 0;
    logic [LANE_W-1:0] cw;
    bpl_dec_t res;
    res.bad = 1'b1;
    res.pay = '0;
    for (int c = 0; c < CODE_SPACE; c++) begin
      cw = c[LANE_W-1:0];
      if (is_balanced(cw)) begin
        if (cw == v && rank < NUM_CODES) begin
          res.bad = 1'b0;
          res.pay = rank[PAY_W-1:0];
        end
        rank++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/bpl_ctrl.sv
module bpl_ctrl
  import bpl_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txValid,
  input  logic      lanesInValid,
  output logic      txReady,
  output bpl_strb_t strb
);

  localparam logic [BEAT_W-1:0] LAST_IDX = BEAT_W'(BEATS - 1);

  logic              txBusy;
  logic [BEAT_W-1:0] txCnt;
  logic [BEAT_W-1:0] rxCnt;
  logic              txLast;
  logic              accept;

  assign txLast  = txBusy && (txCnt == LAST_IDX);
  assign txReady = !txBusy || txLast;
  assign accept  = txValid && txReady;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
    end else if (accept) begin
      txBusy <= 1'b1;
      txCnt  <= '0;
    end else if (txLast) begin
      txBusy <= 1'b0;
      txCnt  <= '0;
    end else if (txBusy) begin
      txCnt  <= txCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxCnt <= '0;
    end else if (lanesInValid) begin
      rxCnt <= (rxCnt == LAST_IDX) ? '0 : rxCnt + 1'b1;
    end
  end

  always_comb begin
    strb.loadWord  = accept;
    strb.emitBeat  = txBusy;
    strb.txIdx     = txCnt;
    strb.takeBeat  = lanesInValid;
    strb.firstBeat = (rxCnt == '0);
    strb.lastBeat  = (rxCnt == LAST_IDX);
  end

endmodule

// File: rtl/bpl_datapath.sv
module bpl_datapath
  import bpl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bpl_strb_t         strb,
  input  logic [WORD_W-1:0] txWord,
  output logic [LANE_W-1:0] lanesOut,
  output logic              lanesOutValid,
  input  logic [LANE_W-1:0] lanesIn,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxWordValid,
  output logic              rxWordErr,
  output logic              rxBeatErr
);

  logic [WORD_W-1:0] wordReg;
  logic [PAY_W-1:0]  txCol;
  bpl_dec_t          rxDec;
  logic              errAcc;
  logic              errNext;
  logic [BEATS-1:0]  grpReg [PAY_W];

  // Transmit: hold the word, pick one bit per group for the current beat
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wordReg <= '0;
    else if (strb.loadWord) wordReg <= txWord;
  end

  always_comb begin
    for (int j = 0; j < PAY_W; j++) begin
      txCol[j] = wordReg[j*BEATS + int'(strb.txIdx)];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lanesOut      <= '0;
      lanesOutValid <= 1'b0;
    end else begin
      lanesOutValid <= strb.emitBeat;
      if (strb.emitBeat) lanesOut <= code_of(txCol);
    end
  end

  // Receive: decode, shift into each group from the top, accumulate errors
  assign rxDec   = decode_of(lanesIn);
  assign errNext = strb.firstBeat ? rxDec.bad : (errAcc | rxDec.bad);

  for (genvar j = 0; j < PAY_W; j++) begin : g_grp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) grpReg[j] <= '0;
      else if (strb.takeBeat) grpReg[j] <= {rxDec.pay[j], grpReg[j][BEATS-1:1]};
    end
    assign rxWord[j*BEATS +: BEATS] = grpReg[j];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errAcc      <= 1'b0;
      rxBeatErr   <= 1'b0;
      rxWordValid <= 1'b0;
      rxWordErr   <= 1'b0;
    end else begin
      rxBeatErr   <= strb.takeBeat && rxDec.bad;
      rxWordValid <= strb.takeBeat && strb.lastBeat;
      if (strb.takeBeat) begin
        errAcc <= errNext;
        if (strb.lastBeat) rxWordErr <= errNext;
      end
    end
  end

  AST_BEAT_WEIGHT: assert property (@(posedge clk) disable iff (!rstN)
    lanesOutValid |-> ($countones(lanesOut) == WEIGHT_LO || $countones(lanesOut) == WEIGHT_HI)); // R2
  AST_LANES_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !lanesOutValid |-> $stable(lanesOut)); // R10
  AST_BEAT_ERR_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    rxBeatErr |-> $past(strb.takeBeat)); // R6
  AST_WORD_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rxWordValid |=> !rxWordValid); // R7

endmodule

// File: rtl/bpl_codec.sv
module bpl_codec
  import bpl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [WORD_W-1:0] txWord,
  input  logic              txValid,
  output logic              txReady,
  output logic [LANE_W-1:0] lanesOut,
  output logic              lanesOutValid,
  input  logic [LANE_W-1:0] lanesIn,
  input  logic              lanesInValid,
  output logic [WORD_W-1:0] rxWord,
  output logic              rxWordValid,
  output logic              rxWordErr,
  output logic              rxBeatErr
);

  bpl_strb_t strb;

  bpl_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .txValid      (txValid),
    .lanesInValid (lanesInValid),
    .txReady      (txReady),
    .strb         (strb)
  );

  bpl_datapath u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .txWord        (txWord),
    .lanesOut      (lanesOut),
    .lanesOutValid (lanesOutValid),
    .lanesIn       (lanesIn),
    .rxWord        (rxWord),
    .rxWordValid   (rxWordValid),
    .rxWordErr     (rxWordErr),
    .rxBeatErr     (rxBeatErr)
  );

  AST_FIRST_BEAT_LAT: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |-> ##2 lanesOutValid); // R3
  AST_STREAM_CONT: assert property (@(posedge clk) disable iff (!rstN)
    !txReady |=> lanesOutValid); // R4

endmodule

// File: tb/bpl_codec_tb.sv
module bpl_codec_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PAY  = 6;
  localparam int LN   = 7;
  localparam int NB   = 32;
  localparam int WW   = PAY * NB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [WW-1:0] txWord = '0;
  logic          txValid = 1'b0;
  logic          txReady;
  logic [LN-1:0] lanesOut;
  logic          lanesOutValid;
  logic [LN-1:0] lanesIn;
  logic          lanesInValid;
  logic [WW-1:0] rxWord;
  logic          rxWordValid, rxWordErr, rxBeatErr;

  logic          loopMode = 1'b1;
  logic [LN-1:0] drvLanes = '0;
  logic          drvValid = 1'b0;

  assign lanesIn      = loopMode ? lanesOut      : drvLanes;
  assign lanesInValid = loopMode ? lanesOutValid : drvValid;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpl_codec u_dut (
    .clk(clk), .rstN(rstN), .txWord(txWord), .txValid(txValid), .txReady(txReady),
    .lanesOut(lanesOut), .lanesOutValid(lanesOutValid),
    .lanesIn(lanesIn), .lanesInValid(lanesInValid),
    .rxWord(rxWord), .rxWordValid(rxWordValid), .rxWordErr(rxWordErr), .rxBeatErr(rxBeatErr)
  );

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  logic [LN-1:0] book [64];
  logic [LN-1:0] beatQ [$];
  logic [WW:0]   wordQ [$];
  bit            prevValid = 0;
  bit            finished = 0;

  task automatic chk(input bit ok, input string req, input logic [199:0] act, input logic [199:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  function automatic logic [WW-1:0] pack_word(input logic [PAY-1:0] p [NB]);
    logic [WW-1:0] w = '0;
    for (int k = 0; k < NB; k++)
      for (int j = 0; j < PAY; j++) w[j*NB + k] = p[k][j];
    return w;
  endfunction

  // Driver: offers a word, pushes its expected beats and word
  task automatic send_word(input logic [WW-1:0] w);
    logic [PAY-1:0] col;
    txWord  = w;
    txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(posedge clk);
    for (int k = 0; k < NB; k++) begin
      for (int j = 0; j < PAY; j++) col[j] = w[j*NB + k];
      beatQ.push_back(book[col]);
    end
    wordQ.push_back({1'b0, w});
    @(negedge clk);
    txValid = 1'b0;
  endtask

  // Monitor
  always @(negedge clk) begin
    if (rstN && !finished) begin
      if (lanesOutValid) begin
        if (beatQ.size() == 0) chk(0, "R3 unexpected beat", 200'(lanesOut), 0);
        else begin
          logic [LN-1:0] e;
          e = beatQ.pop_front();
          chk(lanesOut == e, "R1 codeword", 200'(lanesOut), 200'(e));
        end
        chk($countones(lanesOut) inside {3, 4}, "R2 beat weight", 200'($countones(lanesOut)), 3);
      end else if (prevValid && beatQ.size() != 0) begin
        chk(0, "R4 gap between back-to-back words", 0, 1);
      end
      prevValid = lanesOutValid;
      if (rxWordValid) begin
        if (wordQ.size() == 0) chk(0, "R7 unexpected word", 200'(rxWord), 0);
        else begin
          logic [WW:0] e;
          e = wordQ.pop_front();
          chk(rxWord == e[WW-1:0], "R7 R5 reassembled word", 200'(rxWord), 200'(e[WW-1:0]));
          chk(rxWordErr == e[WW], "R8 word error flag", 200'(rxWordErr), 200'(e[WW]));
        end
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !finished) begin
      finished = 1;
      mismatched++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      summary();
    end
  end

  initial begin
    logic [PAY-1:0] p [NB];
    logic [LN-1:0]  drv [NB];
    bit             bad [NB];
    logic [WW-1:0]  w;
    logic [LN-1:0]  lastCode;
    logic [LN-1:0]  illegal [8];
    int n;

    n = 0;
    for (int v = 0; v < 128; v++) begin
      if (($countones(v[6:0]) == 3 || $countones(v[6:0]) == 4) && n < 64) begin
        book[n] = v[6:0];
        n++;
      end
    end

    repeat (3) @(negedge clk);
    // R9: reset state
    chk(txReady == 1'b1, "R9 txReady", 200'(txReady), 1);
    chk(lanesOut == '0 && !lanesOutValid, "R9 lanes", 200'({lanesOutValid, lanesOut}), 0);
    chk(!rxWordValid && !rxWordErr && !rxBeatErr, "R9 rx flags", 200'({rxWordValid, rxWordErr, rxBeatErr}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R1 spot values
    chk(book[0] == 7'h07 && book[1] == 7'h0B && book[4] == 7'h0F && book[63] == 7'h6A,
        "R1 table spot", 200'({book[0], book[1], book[4], book[63]}), 200'({7'h07, 7'h0B, 7'h0F, 7'h6A}));

    // Word A: payloads 0..31; check R3 first-beat latency
    for (int k = 0; k < NB; k++) p[k] = PAY'(k);
    w = pack_word(p);
    txWord = w; txValid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < NB; k++) beatQ.push_back(book[k]);
    wordQ.push_back({1'b0, w});
    @(negedge clk);
    txValid = 1'b0;
    chk(!lanesOutValid, "R3 no beat one edge after accept", 200'(lanesOutValid), 0);
    @(negedge clk);
    chk(lanesOutValid, "R3 beat two edges after accept", 200'(lanesOutValid), 1);
    @(negedge clk);
    chk(!txReady, "R4 ready low mid word", 200'(txReady), 0);

    // Word B back-to-back: payloads 32..63 (completes all 64 codes)
    for (int k = 0; k < NB; k++) p[k] = PAY'(32 + k);
    send_word(pack_word(p));
    // Word C, random, back-to-back
    send_word({$urandom, $urandom, $urandom, $urandom, $urandom, $urandom});
    // Word D all ones, Word E all zeros
    send_word('1);
    send_word('0);
    repeat (40) @(negedge clk);
    lastCode = book[0];
    repeat (5) @(negedge clk);
    chk(!lanesOutValid && lanesOut == lastCode, "R10 lanes hold last beat", 200'(lanesOut), 200'(lastCode));

    // Direct drive with illegal values
    loopMode = 1'b0;
    illegal[0] = 7'h00; illegal[1] = 7'h7F; illegal[2] = 7'h6C; illegal[3] = 7'h70;
    illegal[4] = 7'h71; illegal[5] = 7'h72; illegal[6] = 7'h74; illegal[7] = 7'h78;
    for (int k = 0; k < NB; k++) begin
      if (k >= 3 && k < 11) begin
        drv[k] = illegal[k-3]; bad[k] = 1; p[k] = '0;
      end else begin
        p[k] = PAY'((k * 5 + 1) % 64); drv[k] = book[p[k]]; bad[k] = 0;
      end
    end
    wordQ.push_back({1'b1, pack_word(p)});
    for (int k = 0; k <= NB; k++) begin
      if (k > 0) chk(rxBeatErr == bad[k-1], "R6 beat error flag", 200'(rxBeatErr), 200'(bad[k-1]));
      if (k < NB) begin
        drvLanes = drv[k]; drvValid = 1'b1;
        @(negedge clk);
      end
    end
    drvValid = 1'b0;
    @(negedge clk);

    // Next word is clean: R8 must clear
    loopMode = 1'b1;
    for (int k = 0; k < NB; k++) p[k] = PAY'(63 - k);
    send_word(pack_word(p));

    for (int t = 0; t < 200 && (beatQ.size() != 0 || wordQ.size() != 0); t++) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(beatQ.size() == 0 && wordQ.size() == 0, "R7 all expected items seen",
        200'(beatQ.size() + wordQ.size()), 0);
    finished = 1;
    summary();
  end

endmodule